// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

This block is the integer arithmetic and logic stage of a 32-bit RISC pipeline. Each cycle it can accept one operation. An operation is made of a 5-bit operation code, two register operands and a 16-bit immediate. One clock edge later it presents the result, a register write-enable and an overflow-trap flag.

The block covers the following operations:
- addition and subtraction, each in a trapping form and a wrapping form;
- logical operations that take a register or an immediate as the second operand;
- left and right shifts, with the amount taken from a register or from the immediate;
- load-upper-immediate.

When a trapping operation overflows, the write is suppressed, so the destination register keeps its old value. The trap flag is handed to the exception logic outside the block.

Operand `opa` is the first source register and `opb` the second. Shifts move `opb` and take their amount from `opa` or from the immediate.

Top module: `int_alu_trap`

## Requirements
- R1: A synchronous active-high `rst` clears `result_q`, `wr_en_q` and `trap_q` to zero.
- R2: The outputs reflect the operation presented with `in_valid` high at the previous rising edge. After a cycle with `in_valid` low, `wr_en_q` and `trap_q` are 0 and `result_q` keeps its previous value.
- R3: For the trapping codes 0 (opa+opb), 2 (opa-opb) and 4 (opa+sext(imm)), a signed overflow sets `trap_q` to 1 and `wr_en_q` to 0. Without an overflow, `trap_q` is 0 and `wr_en_q` is 1.
- R4: The wrapping codes 1 (opa+opb), 3 (opa-opb) and 5 (opa+sext(imm)) return the low 32 bits of the result, assert `wr_en_q` and never assert `trap_q`.
- R5: Codes 4 and 5 sign-extend the immediate, so it lies between -8000h and +7FFFh.
- R6: Codes 6 to 9 return opa AND opb, opa OR opb, opa XOR opb and NOT(opa OR opb), in that order.
- R7: Codes 10 to 12 return AND, OR and XOR of opa with the immediate zero-extended to 0000h..FFFFh.
- R8: The variable shifts move opb by opa[4:0]: code 13 shifts left, code 14 shifts right logically and code 15 shifts right arithmetically. Bits 31:5 of opa are ignored.
- R9: The immediate shifts move opb by imm[4:0]: code 16 shifts left, code 17 shifts right logically and code 18 shifts right arithmetically. A left shift that loses set bits never traps.
- R10: An arithmetic right shift fills the vacated bits with opb[31]. A logical right shift fills them with zeros.
- R11: Code 19 returns the immediate in bits 31:16 and zeros in bits 15:0, with `wr_en_q` set.
- R12: Codes 20 to 31 are undefined. They give `result_q` = 0, `wr_en_q` = 0 and `trap_q` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (see requirements) |
| opa | input | 32 | First source operand; supplies the shift amount for variable shifts |
| opb | input | 32 | Second source operand; the value that shifts move |
| imm | input | 16 | Immediate field |
| result_q | output | 32 | Registered result |
| wr_en_q | output | 1 | Registered destination write-enable |
| trap_q | output | 1 | Registered signed-overflow trap |

## Verification
The hardest cases to reach are the exact edges of signed overflow. One such case is 7FFFFFFFh plus 1, which must trap, next to 7FFFFFFEh plus 1, which must not. Another is subtracting a negative number from the largest positive value. A third is the trapping immediate add with an immediate of 8000h, where a wrong zero-extension would flip the outcome. Random operands rarely land on these edges, so the stimulus applies them as directed vectors. It then runs a long random phase whose operands are drawn half the time from a small pool of extreme values (0, 1, all ones, 7FFFFFFFh, 80000000h). The same phase also sets the upper bits of the shift-amount operand, so that the masking of the amount is exercised.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_T  = 5'd0,
    OP_ADD_W  = 5'd1,
    OP_SUB_T  = 5'd2,
    OP_SUB_W  = 5'd3,
    OP_ADDI_T = 5'd4,
    OP_ADDI_W = 5'd5,
    OP_AND    = 5'd6,
    OP_OR     = 5'd7,
    OP_XOR    = 5'd8,
    OP_NOR    = 5'd9,
    OP_ANDI   = 5'd10,
    OP_ORI    = 5'd11,
    OP_XORI   = 5'd12,
    OP_SLLV   = 5'd13,
    OP_SRLV   = 5'd14,
    OP_SRAV   = 5'd15,
    OP_SLL    = 5'd16,
    OP_SRL    = 5'd17,
    OP_SRA    = 5'd18,
    OP_LUI    = 5'd19
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;

  typedef enum logic [1:0] {
    SH_LEFT   = 2'd0,
    SH_RLOG   = 2'd1,
    SH_RARITH = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;

  // Subtraction is a + ~b + 1, carried in through the low bit.
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};

  // Same-sign addends whose sum changes sign have overflowed.
  assign ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
`timescale 1ns/1ps
module alu_shift
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val_i,
  input  logic [SHW-1:0] amt_i,
  input  shift_kind_e    kind_i,
  output logic [W-1:0]   y_o
);
  logic [W-1:0] pre;
  logic [W-1:0] post;
  logic         fill;
  logic [W-1:0] stage [SHW+1];

  // Left shifts reuse the right-shift network on the bit-reversed value.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      pre[i] = (kind_i == SH_LEFT) ? val_i[W-1-i] : val_i[i];
    end
  end

  assign fill     = (kind_i == SH_RARITH) ? val_i[W-1] : 1'b0;
  assign stage[0] = pre;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
  end

  assign post = stage[SHW];

  always_comb begin
    for (int i = 0; i < W; i++) begin
      y_o[i] = (kind_i == SH_LEFT) ? post[W-1-i] : post[i];
    end
  end
endmodule

// File: rtl/int_alu_trap.sv
`timescale 1ns/1ps
module int_alu_trap
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result_q,
  output logic              wr_en_q,
  output logic              trap_q
);
  localparam int SHW = $clog2(DATA_W);
  localparam int PAD = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx, imm_zx, lui_val;
  logic [DATA_W-1:0] as_b, as_sum, lg_b, lg_y, sh_y;
  logic              as_sub, as_ovf;
  logic_fn_e         lg_fn;
  shift_kind_e       sh_kind;
  logic [SHW-1:0]    sh_amt;
  logic [DATA_W-1:0] res_d;
  logic              known_d, trapping_d, trap_d, wr_d;

  assign imm_sx  = {{PAD{imm[IMM_W-1]}}, imm};
  assign imm_zx  = {{PAD{1'b0}}, imm};
  assign lui_val = {imm, {PAD{1'b0}}};

  // Adder operands
  assign as_sub = (op == OP_SUB_T) || (op == OP_SUB_W);
  assign as_b   = ((op == OP_ADDI_T) || (op == OP_ADDI_W)) ? imm_sx : opb;

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i  (opa),
    .b_i  (as_b),
    .sub_i(as_sub),
    .sum_o(as_sum),
    .ovf_o(as_ovf)
  );

  // Logic operands
  always_comb begin
    lg_b  = opb;
    lg_fn = LG_AND;
    case (op)
      OP_OR:   lg_fn = LG_OR;
      OP_XOR:  lg_fn = LG_XOR;
      OP_NOR:  lg_fn = LG_NOR;
      OP_ANDI: begin lg_b = imm_zx; lg_fn = LG_AND; end
      OP_ORI:  begin lg_b = imm_zx; lg_fn = LG_OR;  end
      OP_XORI: begin lg_b = imm_zx; lg_fn = LG_XOR; end
      default: lg_fn = LG_AND;
    endcase
  end

  alu_logic #(.W(DATA_W)) u_logic (
    .a_i (opa),
    .b_i (lg_b),
    .fn_i(lg_fn),
    .y_o (lg_y)
  );

  // Shift operands
  always_comb begin
    sh_amt  = imm[SHW-1:0];
    sh_kind = SH_LEFT;
    case (op)
      OP_SLLV: begin sh_amt = opa[SHW-1:0]; sh_kind = SH_LEFT;   end
      OP_SRLV: begin sh_amt = opa[SHW-1:0]; sh_kind = SH_RLOG;   end
      OP_SRAV: begin sh_amt = opa[SHW-1:0]; sh_kind = SH_RARITH; end
      OP_SRL:  sh_kind = SH_RLOG;
      OP_SRA:  sh_kind = SH_RARITH;
      default: sh_kind = SH_LEFT;
    endcase
  end

  alu_shift #(.W(DATA_W), .SHW(SHW)) u_shift (
    .val_i (opb),
    .amt_i (sh_amt),
    .kind_i(sh_kind),
    .y_o   (sh_y)
  );

  // Result selection
  always_comb begin
    res_d      = '0;
    known_d    = 1'b1;
    trapping_d = 1'b0;
    case (op)
      OP_ADD_T, OP_SUB_T, OP_ADDI_T: begin res_d = as_sum; trapping_d = 1'b1; end
      OP_ADD_W, OP_SUB_W, OP_ADDI_W: res_d = as_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR,
      OP_ANDI, OP_ORI, OP_XORI:      res_d = lg_y;
      OP_SLLV, OP_SRLV, OP_SRAV,
      OP_SLL, OP_SRL, OP_SRA:        res_d = sh_y;
      OP_LUI:                        res_d = lui_val;
      default:                       known_d = 1'b0;
    endcase
  end

  assign trap_d = in_valid && trapping_d && as_ovf;
  assign wr_d   = in_valid && known_d && !trap_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      wr_en_q  <= 1'b0;
      trap_q   <= 1'b0;
    end else begin
      wr_en_q <= wr_d;
      trap_q  <= trap_d;
      if (in_valid) begin
        result_q <= res_d;
      end
    end
  end
endmodule

// File: rtl/int_alu_trap_chk.sv
`timescale 1ns/1ps
module int_alu_trap_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [IMM_W-1:0]  imm,
  input logic [DATA_W-1:0] result_q,
  input logic              wr_en_q,
  input logic              trap_q
);
  logic trap_op, wrap_op;
  assign trap_op = (op == OP_ADD_T) || (op == OP_SUB_T) || (op == OP_ADDI_T);
  assign wrap_op = (op == OP_ADD_W) || (op == OP_SUB_W) || (op == OP_ADDI_W);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result_q == '0) && !wr_en_q && !trap_q);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> $stable(result_q) && !wr_en_q && !trap_q);

  assert_trap_blocks_write_R3: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> !wr_en_q);

  assert_trap_source_R3: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> $past(in_valid && trap_op));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && wrap_op) |-> wr_en_q && !trap_q);

  assert_upper_imm_R11: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && (op == OP_LUI)) |->
      wr_en_q && (result_q[DATA_W-IMM_W-1:0] == '0) && (result_q[DATA_W-1:DATA_W-IMM_W] == $past(imm)));

  assert_undefined_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && (op > OP_LUI)) |-> !wr_en_q && !trap_q && (result_q == '0));
endmodule

bind int_alu_trap int_alu_trap_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .op      (op),
  .opa     (opa),
  .opb     (opb),
  .imm     (imm),
  .result_q(result_q),
  .wr_en_q (wr_en_q),
  .trap_q  (trap_q)
);

// File: tb/int_alu_trap_bench.sv
`timescale 1ns/1ps
module int_alu_trap_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [15:0] imm = '0;
  logic [31:0] result_q;
  logic        wr_en_q;
  logic        trap_q;

  int applied = 0;
  int bad     = 0;
  bit done    = 1'b0;
  logic [31:0] held_res = '0;

  always #2 clk = ~clk;

  int_alu_trap u_int_alu_trap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa),
    .opb(opb), .imm(imm), .result_q(result_q), .wr_en_q(wr_en_q), .trap_q(trap_q)
  );

  function automatic string tag_of(input logic v, input int o);
    if (!v) return "R2";
    if (o == 0 || o == 2) return "R3";
    if (o == 1 || o == 3) return "R4";
    if (o == 4 || o == 5) return "R5";
    if (o >= 6 && o <= 9) return "R6";
    if (o >= 10 && o <= 12) return "R7";
    if (o == 15 || o == 18) return "R10";
    if (o == 13 || o == 14) return "R8";
    if (o == 16 || o == 17) return "R9";
    if (o == 19) return "R11";
    return "R12";
  endfunction

  task automatic model(input int o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i, output logic [31:0] r,
                       output logic w, output logic t);
    longint sa, sb, s;
    int sx;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sx = int'($signed(i));
    r = 32'h0; w = 1'b1; t = 1'b0;
    case (o)
      0, 1: s = sa + sb;
      2, 3: s = sa - sb;
      4, 5: s = sa + longint'(sx);
      default: s = 0;
    endcase
    case (o)
      0, 1, 2, 3, 4, 5: begin
        r = s[31:0];
        if ((o % 2 == 0) && (s > 64'sd2147483647 || s < -64'sd2147483648)) begin
          t = 1'b1; w = 1'b0;
        end
      end
      6:  r = a & b;
      7:  r = a | b;
      8:  r = a ^ b;
      9:  r = ~(a | b);
      10: r = a & {16'h0, i};
      11: r = a | {16'h0, i};
      12: r = a ^ {16'h0, i};
      13: r = b << (a % 32);
      14: r = b >> (a % 32);
      15: r = $unsigned($signed(b) >>> (a % 32));
      16: r = b << (i % 32);
      17: r = b >> (i % 32);
      18: r = $unsigned($signed(b) >>> (i % 32));
      19: r = {i, 16'h0};
      default: begin r = 32'h0; w = 1'b0; end
    endcase
  endtask

  task automatic apply(input logic v, input int o, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i);
    logic [31:0] er;
    logic ew, et;
    @(negedge clk);
    in_valid = v; op = o[4:0]; opa = a; opb = b; imm = i;
    if (v) begin
      model(o, a, b, i, er, ew, et);
      held_res = er;
    end else begin
      er = held_res; ew = 1'b0; et = 1'b0;
    end
    @(posedge clk);
    #1;
    applied++;
    if (result_q !== er || wr_en_q !== ew || trap_q !== et) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h: got res=%h wr=%b trap=%b, expected res=%h wr=%b trap=%b",
               tag_of(v, o), o, a, b, i, result_q, wr_en_q, trap_q, er, ew, et);
    end
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] pool [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
    if ($urandom_range(0, 1) == 0) return pool[$urandom_range(0, 4)];
    return $urandom;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared by reset
    applied++;
    if (result_q !== 32'h0 || wr_en_q !== 1'b0 || trap_q !== 1'b0) begin
      bad++;
      $display("FAIL R1 got res=%h wr=%b trap=%b, expected 0 0 0", result_q, wr_en_q, trap_q);
    end
    // R3 overflow edges
    apply(1, 0, 32'h7FFF_FFFF, 32'h1, 16'h0);
    apply(1, 0, 32'h7FFF_FFFE, 32'h1, 16'h0);
    apply(1, 0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
    apply(1, 2, 32'h8000_0000, 32'h1, 16'h0);
    apply(1, 2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0);
    apply(1, 2, 32'h0, 32'h8000_0000, 16'h0);
    // R4 wrapping forms
    apply(1, 1, 32'h7FFF_FFFF, 32'h1, 16'h0);
    apply(1, 3, 32'h8000_0000, 32'h1, 16'h0);
    apply(1, 5, 32'h7FFF_FFFF, 32'h0, 16'h0001);
    // R5 sign-extended immediate, including trap via immediate
    apply(1, 4, 32'h8000_0000, 32'h0, 16'h8000);
    apply(1, 4, 32'h7FFF_FFFF, 32'h0, 16'h7FFF);
    apply(1, 5, 32'h0000_0010, 32'h0, 16'hFFFF);
    // R2 idle hold
    apply(0, 6, 32'h1234_5678, 32'h0, 16'h0);
    // R6/R7 logic
    apply(1, 9, 32'hF0F0_0000, 32'h0000_0F0F, 16'h0);
    apply(1, 10, 32'hFFFF_FFFF, 32'h0, 16'hFFFF);
    apply(1, 11, 32'h8000_0000, 32'h0, 16'h8001);
    apply(1, 12, 32'hFFFF_FFFF, 32'h0, 16'hFFFF);
    // R8 amount masking, R10 fill, R9 lost bits
    apply(1, 13, 32'hFFFF_FFE5, 32'h0000_0003, 16'h0);
    apply(1, 15, 32'h0000_0024, 32'h8000_0000, 16'h0);
    apply(1, 14, 32'h0000_001F, 32'h8000_0000, 16'h0);
    apply(1, 16, 32'h0, 32'hC000_0001, 16'h001F);
    apply(1, 18, 32'h0, 32'h8765_4321, 16'hFFE8);
    // R11, R12
    apply(1, 19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF);
    apply(1, 20, 32'h1, 32'h1, 16'h1);
    apply(1, 31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);
    apply(0, 0, 32'h0, 32'h0, 16'h0);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      apply(($urandom_range(0, 7) != 0), int'($urandom_range(0, 31)), pick(), pick(), 16'($urandom));
    end
    finish_run();
  end
endmodule